// File: doc/BRIEF.md
# Reloading down-counter timer unit

The block is a memory-mapped timer with a parameterised number of identical channels (three by default). Each channel holds a down-counter, a reload constant and a small control register. A shared prescaler divides the clock by 4, 16, 64, 256 or 1024, and each channel picks one of those rates. While its start bit is set, a channel decrements once per selected tick. When a tick finds the counter at zero, the channel reloads the counter from the constant and sets a sticky underflow flag. While the flag and the interrupt enable are both set, the channel's interrupt line is driven high.

Software reaches the registers over a single-cycle read/write port. The port supports byte, word and long accesses. Write data and read data are lane-aligned on a 32-bit bus. Read data appears on the cycle after the request. Two shared registers sit at the bottom of the map. The channel groups follow, 12 bytes apart, with the first group at offset 0x8.

Top module: `tmr_unit`

## Requirements
- R1: After reset, every register reads 0 and every interrupt line is low.
- R2: The address map is as follows: offset 0x0 holds an 8-bit output-control byte, and offset 0x4 holds the start register, whose bit i runs channel i. Channel i's constant is at 0x8+12i, its counter at 0xC+12i and its control at 0x10+12i. Read data is registered and valid on the cycle after the request. An unmapped address reads 0.
- R3: The size code selects the access width: 0 is a byte, 1 is a word and 2 is a long. A byte access writes only lane addr[1:0], a word access writes lanes 2*addr[1] and 2*addr[1]+1, and a long access writes all four lanes. Write data is lane-aligned, and bits outside the selected lanes leave the register unchanged.
- R4: A stopped channel holds its count. Its counter, constant and control registers still accept writes, and the other channels are unaffected.
- R5: A running channel decrements once per selected tick. A tick that finds the counter at 0 reloads it from the constant, so the gap between successive underflows is (C+1)*divisor clocks.
- R6: Control bits [2:0] select the divisor: 0 gives /4, 1 gives /16, 2 gives /64, 3 gives /256 and 4 gives /1024. Values 5 to 7 hold the count.
- R7: Control bit 8 is the underflow flag. Hardware sets it on underflow. Writing 0 to it clears it, and writing 1 to it has no effect.
- R8: Each interrupt line is high exactly while its channel's flag (bit 8) and interrupt enable (bit 5) are both set.
- R9: In the control register, only bits 8, 5 and [2:0] read back, and the other bits read 0. The output-control byte reads back whatever was written to it and affects no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access width: 0 byte, 1 word, 2 long |
| wdata_i | input | 32 | Lane-aligned write data |
| rdata_o | output | 32 | Registered read data of the addressed register |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
The bench builds the block with its default parameters: three channels, 32-bit counters and the full five-step prescaler. At these values, even the /1024 rate has a period of a few thousand clocks, so every divisor can be measured on channel 0, and channels 1 and 2 can be measured at two divisors each. Each measurement gives the exact underflow gap (C+1)*divisor and the reloaded count. The small size also keeps within reach the lane-masking cases, the flag write semantics and the hold codes, each of which is checked through reads and the interrupt pins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NPRE   = 5;      // prescale steps /4 .. /1024
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      SZ_BYTE: lane_mask = 4'b0001 << lo;
      SZ_WORD: lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [3:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    merge = (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int NPRE = tmr_pkg::NPRE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [NPRE-1:0] tick_o
);
  localparam int PW = 2 * NPRE;
  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;

  // step k fires once every 4^(k+1) clocks
  for (genvar k = 0; k < NPRE; k++) begin : g_tick
    assign tick_o[k] = &div_q[2*k+1:0];
    if (k > 0) begin : g_nest
      AST_TICK_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[k] |-> tick_o[k-1]); // R6
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]); // R6
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int NPRE  = tmr_pkg::NPRE,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPRE-1:0]  tick_i,
  input  logic             run_i,
  input  logic [3:0]       be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic             const_we_i,
  input  logic             cnt_we_i,
  input  logic             ctrl_we_i,
  output logic [CNT_W-1:0] const_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [15:0]      ctrl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] const_q, cnt_q;
  logic [2:0]       tpsc_q;
  logic             ie_q, flag_q;
  logic             tick_sel, step, underflow, flag_clr;
  logic [DATA_W-1:0] const_w, cnt_w;

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < NPRE; k++)
      if (tpsc_q == 3'(k)) tick_sel = tick_i[k];
  end

  assign const_w   = merge(DATA_W'(const_q), wdata_i, be_i);
  assign cnt_w     = merge(DATA_W'(cnt_q), wdata_i, be_i);
  assign step      = run_i && tick_sel && !cnt_we_i;
  assign underflow = step && (cnt_q == '0);
  assign flag_clr  = ctrl_we_i && be_i[1] && !wdata_i[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      const_q <= '0;
      cnt_q   <= '0;
      tpsc_q  <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (const_we_i) const_q <= CNT_W'(const_w);
      if (cnt_we_i)       cnt_q <= CNT_W'(cnt_w);
      else if (underflow) cnt_q <= const_q;
      else if (step)      cnt_q <= cnt_q - 1'b1;
      if (ctrl_we_i && be_i[0]) begin
        tpsc_q <= wdata_i[2:0];
        ie_q   <= wdata_i[5];
      end
      // set beats a same-cycle clear
      if (underflow)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign ctrl_o  = {7'b0, flag_q, 2'b0, ie_q, 2'b0, tpsc_q};
  assign irq_o   = flag_q & ie_q;

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_sel && cnt_q == '0 && !cnt_we_i) |=> (cnt_q == $past(const_q) && flag_q)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q)); // R4
  AST_HOLD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpsc_q > 3'(NPRE-1) && !cnt_we_i) |=> $stable(cnt_q)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(ctrl_we_i && be_i[1] && !wdata_i[8])) |=> flag_q); // R7
  AST_FLAG_ONLY_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(run_i && tick_sel && cnt_q == '0)) |=> !flag_q); // R7
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int WI_W = ADDR_W - 2;
  localparam int IDX_OCR = 0;
  localparam int IDX_STR = 1;
  localparam int IDX_CH0 = 2;   // 3 words per channel from here

  logic [WI_W-1:0] widx;
  logic [3:0]      be;
  logic            wr;
  logic [7:0]      ocr_q;
  logic [NCH-1:0]  start_q;
  logic [NPRE-1:0] tick;
  logic [CNT_W-1:0] ch_const [NCH];
  logic [CNT_W-1:0] ch_cnt   [NCH];
  logic [15:0]      ch_ctrl  [NCH];
  logic [31:0]     rd_mux;

  assign widx = addr_i[ADDR_W-1:2];
  assign be   = lane_mask(size_i, addr_i[1:0]);
  assign wr   = req_i && we_i;

  tmr_prescaler #(.NPRE(NPRE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.NPRE(NPRE), .CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .run_i      (start_q[i]),
      .be_i       (be),
      .wdata_i    (wdata_i),
      .const_we_i (wr && widx == WI_W'(IDX_CH0 + 3*i)),
      .cnt_we_i   (wr && widx == WI_W'(IDX_CH0 + 3*i + 1)),
      .ctrl_we_i  (wr && widx == WI_W'(IDX_CH0 + 3*i + 2)),
      .const_o    (ch_const[i]),
      .cnt_o      (ch_cnt[i]),
      .ctrl_o     (ch_ctrl[i]),
      .irq_o      (irq_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q   <= '0;
      start_q <= '0;
    end else if (wr && be[0]) begin
      if (widx == WI_W'(IDX_OCR)) ocr_q   <= wdata_i[7:0];
      if (widx == WI_W'(IDX_STR)) start_q <= wdata_i[NCH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (widx == WI_W'(IDX_OCR)) rd_mux = 32'(ocr_q);
    if (widx == WI_W'(IDX_STR)) rd_mux = 32'(start_q);
    for (int i = 0; i < NCH; i++) begin
      if (widx == WI_W'(IDX_CH0 + 3*i))     rd_mux = 32'(ch_const[i]);
      if (widx == WI_W'(IDX_CH0 + 3*i + 1)) rd_mux = 32'(ch_cnt[i]);
      if (widx == WI_W'(IDX_CH0 + 3*i + 2)) rd_mux = 32'(ch_ctrl[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_mux;

  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R2
  AST_IRQ_NEEDS_START_OR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q == '0 && !wr) |=> !$rose(|irq_o)); // R8
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  localparam int NCH = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  tmr_unit u_tmr_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] a_const(int ch); return 6'(8 + 12*ch);  endfunction
  function automatic logic [5:0] a_cnt(int ch);   return 6'(12 + 12*ch); endfunction
  function automatic logic [5:0] a_ctrl(int ch);  return 6'(16 + 12*ch); endfunction

  task automatic chk(input bit ok, input string req_s, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_s, act, exp_v);
    end
  endtask

  task automatic done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
    req = 1; we = 1; addr = a; size = sz; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a; size = 2'd2;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, output int t);
    int guard = 0;
    while (!irq[ch] && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
    chk(irq[ch], "R8 irq timeout", 32'(irq), 32'(1 << ch));
  endtask

  task automatic measure(input int ch, input int k, input int c);
    int t1, t2, per;
    logic [31:0] v;
    per = (c + 1) * (4 << (2*k));
    wr(6'h04, 2'd0, 32'h0);
    wr(a_ctrl(ch), 2'd1, 32'h20 | k);
    wr(a_const(ch), 2'd2, c);
    wr(a_cnt(ch), 2'd2, c);
    wr(6'h04, 2'd0, 32'(1 << ch));
    wait_irq(ch, t1);
    rd(a_cnt(ch), v);
    chk(v == 32'(c), "R5 reload value", v, c);
    wr(a_ctrl(ch), 2'd1, 32'h20 | k);
    chk(irq[ch] == 1'b0, "R7 clear by zero", 32'(irq[ch]), 0);
    wait_irq(ch, t2);
    chk(t2 - t1 == per, "R5 R6 underflow gap", 32'(t2 - t1), 32'(per));
    chk((irq & ~(3'(1 << ch))) == '0, "R4 other channels quiet", 32'(irq), 32'(1 << ch));
    wr(6'h04, 2'd0, 32'h0);
    wr(a_ctrl(ch), 2'd1, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1;
    idle(1);

    // reset state
    for (int w = 0; w < 11; w++) begin
      rd(6'(4*w), v);
      chk(v == 0, "R1 reset value", v, 0);
    end
    chk(irq == '0, "R1 irq at reset", 32'(irq), 0);
    rd(6'h30, v);
    chk(v == 0, "R2 unmapped reads 0", v, 0);

    // output-control byte
    wr(6'h00, 2'd0, 32'hFFFF_FFA5);
    rd(6'h00, v);
    chk(v == 32'hA5, "R9 output-control readback", v, 32'hA5);

    // lane masking on channel 0 constant
    wr(a_const(0), 2'd2, 32'h1122_3344);
    wr(a_const(0) + 1, 2'd0, 32'h0000_AB00);
    rd(a_const(0), v);
    chk(v == 32'h1122_AB44, "R3 byte lane 1", v, 32'h1122_AB44);
    wr(a_const(0) + 2, 2'd1, 32'hCDEF_0000);
    rd(a_const(0), v);
    chk(v == 32'hCDEF_AB44, "R3 upper word", v, 32'hCDEF_AB44);
    wr(a_const(0), 2'd0, 32'h7777_7799);
    rd(a_const(0), v);
    chk(v == 32'hCDEF_AB99, "R3 byte lane 0 masked", v, 32'hCDEF_AB99);
    rd(a_const(1), v);
    chk(v == 0, "R2 channel 1 constant untouched", v, 0);

    // control bit visibility, writing 1 to flag
    wr(a_ctrl(2), 2'd2, 32'hFFFF_FFFF);
    rd(a_ctrl(2), v);
    chk(v == 32'h0027, "R9 R7 control readback", v, 32'h0027);
    chk(irq == '0, "R7 write 1 no effect", 32'(irq), 0);
    wr(a_ctrl(2), 2'd1, 32'h0);

    // stopped channel holds, counter writable
    wr(a_ctrl(0), 2'd1, 32'h0);
    wr(a_cnt(0), 2'd2, 32'h0000_0100);
    idle(200);
    rd(a_cnt(0), v);
    chk(v == 32'h100, "R4 stopped holds", v, 32'h100);

    // hold codes while running
    wr(a_ctrl(0), 2'd1, 32'h5);
    wr(6'h04, 2'd0, 32'h1);
    idle(2100);
    rd(a_cnt(0), v);
    chk(v == 32'h100, "R6 code 5 holds", v, 32'h100);
    wr(a_ctrl(0), 2'd1, 32'h7);
    idle(2100);
    rd(a_cnt(0), v);
    chk(v == 32'h100, "R6 code 7 holds", v, 32'h100);

    // decrement rate at /4 over 40 clocks
    wr(a_ctrl(0), 2'd1, 32'h0);
    rd(a_cnt(0), v);
    idle(39);
    rd(a_cnt(0), v2);
    chk(v - v2 == 10, "R5 ten ticks in 40 clocks", v - v2, 10);
    wr(6'h04, 2'd0, 32'h0);

    // flag with interrupt disabled, then enable and clear
    wr(a_const(0), 2'd2, 32'h1);
    wr(a_cnt(0), 2'd2, 32'h1);
    wr(6'h04, 2'd0, 32'h1);
    idle(20);
    wr(6'h04, 2'd0, 32'h0);
    rd(a_ctrl(0), v);
    chk(v == 32'h0100, "R7 flag set on underflow", v, 32'h0100);
    chk(irq == '0, "R8 masked flag keeps irq low", 32'(irq), 0);
    wr(a_ctrl(0), 2'd1, 32'h0120);
    chk(irq == 3'b001, "R8 enable raises irq", 32'(irq), 1);
    rd(a_ctrl(0), v);
    chk(v == 32'h0120, "R7 write 1 keeps flag", v, 32'h0120);
    wr(a_ctrl(0), 2'd1, 32'h0020);
    chk(irq == '0, "R7 write 0 clears", 32'(irq), 0);
    rd(a_ctrl(0), v);
    chk(v == 32'h0020, "R7 flag cleared", v, 32'h0020);

    // period sweep
    for (int k = 0; k < 5; k++) begin
      measure(0, k, 1);
      measure(0, k, 2);
    end
    measure(1, 0, 3);
    measure(1, 2, 1);
    measure(2, 1, 2);
    measure(2, 3, 1);

    done();
  end
endmodule